// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every element of a packed data vector by its own amount. The amount for element k is the unsigned value held in element k of a second vector, the count vector, which has the same layout. Elements are 32 or 64 bits wide. The vector is 256 bits wide, or 128 bits when the narrow mode is selected. The block offers three operations: logical left, logical right and arithmetic right. Arithmetic right is defined for 32-bit elements only.

Each lane tests its own count against the element width. A lane whose count is too large saturates without affecting its neighbours. A logical shift saturates to zero. An arithmetic shift saturates to a copy of the lane's sign bit. The result and an illegal-operation flag are registered, so they appear one clock after the operands.

Top module: `vshift_var`

## Requirements
- R1: With 32-bit elements (`elem64_i`=0), the 32-bit lane k of `result_o` is lane k of `data_i` shifted by the unsigned value of lane k of `cnt_i`, and each lane uses its own count.
- R2: With 64-bit elements (`elem64_i`=1), each 64-bit lane is shifted by the whole unsigned 64-bit value of the matching count lane.
- R3: Operation code `op_i`=2'b00 shifts left and fills the vacated low bits with zeros.
- R4: Operation code `op_i`=2'b01 shifts right and fills the vacated high bits with zeros.
- R5: Operation code `op_i`=2'b10 on 32-bit elements shifts right and fills the vacated high bits with the lane's bit 31.
- R6: In a logical shift, a lane whose count is larger than the element width minus one (31 or 63) gives zero. Only that lane is affected.
- R7: In an arithmetic shift, a lane whose count is larger than 31 gives 32'hFFFFFFFF when bit 31 of that lane is set, and zero when it is clear.
- R8: The full count lane is compared, so a 32-bit count of 0x100 is out of range and is not treated as 0.
- R9: With `wide_i`=0 (128-bit mode), only the lanes in bits 127:0 are computed, and `result_o[255:128]` is zero. With `wide_i`=1, all 256 bits are computed.
- R10: Operation code 2'b10 with 64-bit elements, and the reserved code 2'b11, set `illegal_o` and give an all-zero result.
- R11: Results and `illegal_o` are registered with a latency of one clock. While `rst_n` is low, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_i | input | 256 | Packed data vector |
| cnt_i | input | 256 | Packed per-lane shift counts, same layout as data |
| elem64_i | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| wide_i | input | 1 | 0: 128-bit vector, 1: 256-bit vector |
| op_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| result_o | output | 256 | Registered shifted vector |
| illegal_o | output | 1 | Registered illegal-operation flag |

## Verification
The only state in the block is the output register, so any wrong internal decision shows at the ports exactly one clock after the operands that caused it. A wrong range test shows up in that lane alone. It appears as a shifted value where zero or a sign copy was due, or as saturation where a real shift was due. Counts of exactly 31/32, 63/64, 0x100 and all-ones sit at the boundary of each lane's range test. A wrong width or mode select would corrupt lanes that do not align between the 32-bit and 64-bit layouts, or would leak data into the upper half in 128-bit mode. Both show up when operands are compared every cycle against an independent bit-level model.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  typedef enum logic [1:0] {
    SH_LL  = 2'b00,
    SH_LR  = 2'b01,
    SH_AR  = 2'b10,
    SH_RSV = 2'b11
  } shop_e;

  localparam int EW_NARROW = 32;
  localparam int EW_WIDE   = 64;

  // an operation is legal unless it is reserved or arithmetic on 64-bit lanes
  function automatic logic op_illegal(input shop_e op, input logic elem64);
    return (op == SH_RSV) || (elem64 && op == SH_AR);
  endfunction
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
  import vshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] cnt_i,
  input  shop_e        op_i,
  output logic [W-1:0] res_o,
  output logic         over_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] amt;
  assign amt    = cnt_i[SW-1:0];
  // any count bit above the in-range field means count > W-1
  assign over_o = |cnt_i[W-1:SW];

  function automatic logic [W-1:0] lane_shift(input logic [W-1:0] d,
                                              input logic [SW-1:0] a,
                                              input logic ovr,
                                              input shop_e op);
    logic [W-1:0] r;
    case (op)
      SH_LL:   r = ovr ? '0 : (d << a);
      SH_LR:   r = ovr ? '0 : (d >> a);
      SH_AR:   r = ovr ? {W{d[W-1]}} : W'($signed(d) >>> a);
      default: r = '0;
    endcase
    return r;
  endfunction

  assign res_o = lane_shift(data_i, amt, over_o, op_i);
endmodule

// File: rtl/vshift_var.sv
module vshift_var
  import vshift_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] cnt_i,
  input  logic             elem64_i,
  input  logic             wide_i,
  input  logic [1:0]       op_i,
  output logic [VEC_W-1:0] result_o,
  output logic             illegal_o
);
  localparam int HALF = VEC_W / 2;
  localparam int N32  = VEC_W / EW_NARROW;
  localparam int N64  = VEC_W / EW_WIDE;

  shop_e            op;
  logic [VEC_W-1:0] res32, res64, sel, nxt;
  logic [N32-1:0]   over32;
  logic [N64-1:0]   over64;
  logic             illegal_now;

  assign op = shop_e'(op_i);

  for (genvar g = 0; g < N32; g++) begin : g_l32
    vshift_lane #(.W(EW_NARROW)) u_lane (
      .data_i (data_i[g*EW_NARROW +: EW_NARROW]),
      .cnt_i  (cnt_i[g*EW_NARROW +: EW_NARROW]),
      .op_i   (op),
      .res_o  (res32[g*EW_NARROW +: EW_NARROW]),
      .over_o (over32[g])
    );
  end

  for (genvar g = 0; g < N64; g++) begin : g_l64
    vshift_lane #(.W(EW_WIDE)) u_lane (
      .data_i (data_i[g*EW_WIDE +: EW_WIDE]),
      .cnt_i  (cnt_i[g*EW_WIDE +: EW_WIDE]),
      .op_i   (op),
      .res_o  (res64[g*EW_WIDE +: EW_WIDE]),
      .over_o (over64[g])
    );
  end

  assign illegal_now = op_illegal(op, elem64_i);
  assign sel         = elem64_i ? res64 : res32;

  always_comb begin
    nxt = sel;
    if (illegal_now) nxt = '0;
    if (!wide_i) nxt[VEC_W-1:HALF] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= nxt;
      illegal_o <= illegal_now;
    end
  end
endmodule

// File: rtl/vshift_var_chk.sv
module vshift_var_chk #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] data_i,
  input logic [VEC_W-1:0] cnt_i,
  input logic             elem64_i,
  input logic             wide_i,
  input logic [1:0]       op_i,
  input logic [VEC_W-1:0] result_o,
  input logic             illegal_o,
  input logic [VEC_W/32-1:0] over32
);
  localparam int HALF = VEC_W / 2;

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((elem64_i && op_i == 2'b10) || op_i == 2'b11) |=> (illegal_o && result_o == '0));

  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> result_o[VEC_W-1:HALF] == '0);

  // R6
  lane0_ll_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem64_i && op_i == 2'b00 && over32[0]) |=> result_o[31:0] == 32'd0);

  // R7
  lane0_ar_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem64_i && op_i == 2'b10 && over32[0]) |=> result_o[31:0] == {32{$past(data_i[31])}});

  // R1
  lane0_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem64_i && op_i != 2'b11 && cnt_i[31:0] == 32'd0) |=> result_o[31:0] == $past(data_i[31:0]));

  // R8
  lane0_hi_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem64_i && cnt_i[31:0] == 32'h100) |-> over32[0]);
endmodule

bind vshift_var vshift_var_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .cnt_i(cnt_i),
  .elem64_i(elem64_i), .wide_i(wide_i), .op_i(op_i),
  .result_o(result_o), .illegal_o(illegal_o), .over32(over32)
);

// File: tb/tb_vshift_var.sv
module tb_vshift_var;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] data_i = '0, cnt_i = '0;
  logic         elem64_i = 1'b0, wide_i = 1'b1;
  logic [1:0]   op_i = 2'b00;
  logic [255:0] result_o;
  logic         illegal_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vshift_var dut (.clk(clk), .rst_n(rst_n), .data_i(data_i), .cnt_i(cnt_i),
    .elem64_i(elem64_i), .wide_i(wide_i), .op_i(op_i),
    .result_o(result_o), .illegal_o(illegal_o));

  // bitwise behavioural model: each result bit picked from its source bit
  function automatic logic [255:0] model(logic [255:0] d, logic [255:0] c,
                                         logic e64, logic wd, logic [1:0] op);
    logic [255:0] r = '0;
    int w = e64 ? 64 : 32;
    int n = (wd ? 256 : 128) / w;
    if (op == 2'b11 || (e64 && op == 2'b10)) return r;
    for (int l = 0; l < n; l++) begin
      int base = l * w;
      logic [63:0] cv = '0;
      logic sg = d[base + w - 1];
      bit inr;
      int a;
      for (int b = 0; b < w; b++) cv[b] = c[base + b];
      inr = (cv < 64'(w));
      a = inr ? int'(cv) : 0;
      for (int b = 0; b < w; b++) begin
        case (op)
          2'b00: r[base+b] = (inr && b >= a) ? d[base + b - a] : 1'b0;
          2'b01: r[base+b] = (inr && b + a < w) ? d[base + b + a] : 1'b0;
          default: r[base+b] = (inr && b + a < w) ? d[base + b + a] : sg;
        endcase
      end
    end
    return r;
  endfunction

  task automatic step(string tag, logic [255:0] d, logic [255:0] c,
                      logic e64, logic wd, logic [1:0] op);
    logic [255:0] er;
    logic ei;
    data_i = d; cnt_i = c; elem64_i = e64; wide_i = wd; op_i = op;
    er = model(d, c, e64, wd, op);
    ei = (op == 2'b11) || (e64 && op == 2'b10);
    @(negedge clk);
    checks++;
    if (result_o !== er || illegal_o !== ei) begin
      fails++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, result_o, illegal_o, er, ei);
    end
  endtask

  function automatic logic [255:0] rep32(logic [31:0] v);
    return {8{v}};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] d, c;
    data_i = {8{32'hDEADBEEF}}; cnt_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    checks++;
    if (result_o !== '0 || illegal_o !== 1'b0) begin
      fails++;
      $display("FAIL R11: result=%h illegal=%b expected 0 0", result_o, illegal_o);
    end
    rst_n = 1'b1;
    d = {32'h80000001, 32'h12345678, 32'hF0F0F0F0, 32'h0000FFFF,
         32'h87654321, 32'hFFFFFFFF, 32'h00000001, 32'hA5A5A5A5};
    c = {32'd0, 32'd1, 32'd4, 32'd8, 32'd15, 32'd16, 32'd31, 32'd3};
    step("R1_R3", d, c, 1'b0, 1'b1, 2'b00);
    step("R1_R4", d, c, 1'b0, 1'b1, 2'b01);
    step("R5", d, c, 1'b0, 1'b1, 2'b10);
    c = {32'd32, 32'd31, 32'h100, 32'hFFFFFFFF, 32'd33, 32'd0, 32'h80000000, 32'd1};
    step("R6", d, c, 1'b0, 1'b1, 2'b00);
    step("R6", d, c, 1'b0, 1'b1, 2'b01);
    step("R7", d, c, 1'b0, 1'b1, 2'b10);
    step("R8", d, {8{32'h100}}, 1'b0, 1'b1, 2'b01);
    d = {64'h8000000000000001, 64'h0123456789ABCDEF, 64'hFFFFFFFF00000000, 64'h00000000FFFFFFFF};
    c = {64'd63, 64'd64, 64'd32, 64'd1};
    step("R2_R3", d, c, 1'b1, 1'b1, 2'b00);
    step("R2_R4", d, c, 1'b1, 1'b1, 2'b01);
    step("R6", d, {64'h100, 64'd40, 64'hFFFFFFFFFFFFFFFF, 64'd0}, 1'b1, 1'b1, 2'b01);
    step("R9", d, {4{64'd4}}, 1'b1, 1'b0, 2'b00);
    step("R9", rep32(32'h80000000), rep32(32'd2), 1'b0, 1'b0, 2'b10);
    step("R10", d, c, 1'b1, 1'b1, 2'b10);
    step("R10", d, c, 1'b0, 1'b1, 2'b11);
    step("R1", d, '0, 1'b0, 1'b1, 2'b00);
    for (int i = 0; i < 400; i++) begin
      logic [255:0] rd, rc;
      for (int k = 0; k < 8; k++) begin
        rd[k*32 +: 32] = $urandom;
        rc[k*32 +: 32] = ($urandom % 4 == 0) ? $urandom : ($urandom % 70);
      end
      step("R1_R2", rd, rc, 1'($urandom), 1'($urandom), 2'($urandom));
    end
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (result_o !== '0 || illegal_o !== 1'b0) begin
      fails++;
      $display("FAIL R11: result=%h illegal=%b expected 0 0", result_o, illegal_o);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule